// File: doc/BRIEF.md
# ADC Channel-Select Sequencer

This controller runs a two-channel analog-to-digital converter whose conversions are started by its select bus, not by a start strobe. The select bus has one bit per channel and at most one bit set. A conversion begins when the bus goes from all zeros to a nonzero value, and every change of the bus passes through all zeros. The sequencer also drives the converter's power-down input, which holds the converter off while high.

A client asks for a conversion by presenting a channel number with a request strobe while `req_ready` is high. If the converter is off, the sequencer releases power-down and waits `wake_cycles + 1` cycles with the select at zero. It then drives the one-hot select code and waits for the data-valid strobe. When the strobe arrives it captures the result, reports it with a one-cycle `done` pulse, and returns the select to zero. If no strobe arrives within `TIMEOUT` cycles, the sequencer gives up, pulses `tmo_abort` and returns the select to zero. A channel number the converter does not have is refused with a one-cycle `req_err` pulse.

The controller has five states. OFF means powered down and ready. WAKE is the settling window. CONV means the select is driven. GAP is a one-cycle zero-select guard. IDLE means powered and ready. The transitions are:
- start-cold: OFF to WAKE
- wake-done: WAKE to CONV
- capture and abandon: CONV to GAP
- settle: GAP to IDLE
- start-warm: IDLE to CONV
- sleep: IDLE to OFF

Top module: `adc_chsel_seq`

## Requirements
- R1: `adc_sel` is all zeros or has exactly one bit set. When channel k is converted, bit k is the one set (channel 0 gives 2'b01, channel 1 gives 2'b10).
- R2: `adc_sel` never changes from one nonzero value to another. After each conversion ends, it stays zero for at least one cycle before the next conversion begins.
- R3: `adc_pd` is high exactly in OFF, and `adc_sel` is zero whenever `adc_pd` is high.
- R4: A legal request accepted in OFF lowers `adc_pd` in the next cycle. `adc_sel` then stays zero for `wake_cycles + 1` cycles and is driven in the cycle after that.
- R5: A legal request accepted in IDLE drives `adc_sel` in the next cycle, with no wake window.
- R6: When `adc_valid` is high during a conversion, `done` is high for exactly one cycle in the next cycle. In that cycle `done_data` holds the sampled `adc_data` and `done_chan` holds the channel number. `adc_sel` is zero in the same cycle.
- R7: If `adc_valid` is not seen during the first `TIMEOUT` cycles of a conversion, `tmo_abort` pulses for one cycle, `adc_sel` returns to zero and `done` stays low. A strobe in the last of those cycles still counts as a capture.
- R8: A request whose channel code is `NUM_CH` or greater, made while `req_ready` is high, pulses `req_err` for one cycle in the next cycle and starts no conversion.
- R9: Requests made while `req_ready` is low are ignored and raise no error. An `adc_valid` outside a conversion produces no `done`.
- R10: In IDLE with `keep_pwr` low and no legal request, the sequencer enters OFF on the next cycle. A legal request in the same cycle takes priority over the power-off.
- R11: After reset the sequencer is in OFF: `adc_pd` and `req_ready` are high, and `adc_sel`, `done`, `tmo_abort` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Conversion request strobe |
| req_chan | input | CH_W | Requested channel number |
| wake_cycles | input | WAKE_W | Extra settling cycles after power-up |
| keep_pwr | input | 1 | Keep the converter powered while idle |
| req_ready | output | 1 | Requests are accepted in this cycle |
| req_err | output | 1 | Illegal-channel pulse |
| adc_pd | output | 1 | Converter power-down, high means off |
| adc_sel | output | NUM_CH | One-hot channel select |
| adc_valid | input | 1 | Converter data-valid strobe |
| adc_data | input | DATA_W | Converter result |
| done | output | 1 | Result-ready pulse |
| done_chan | output | CH_W | Channel of the last result or abort |
| done_data | output | DATA_W | Last captured result |
| tmo_abort | output | 1 | Conversion-timeout pulse |

## Verification
In CONV, the data-valid strobe and the end of the timeout window can arrive in the same cycle. The capture must win, so `done` fires and `tmo_abort` does not. The bench provokes this by setting its converter model to answer after exactly `TIMEOUT - 1` cycles, and also checks one cycle later, where the abort must fire and the late strobe must be ignored. A second collision happens in IDLE, where a legal request meets `keep_pwr` low. The bench raises both in the same cycle and expects the select to be driven next, with the power still on.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        S_OFF  = 3'd0,
        S_WAKE = 3'd1,
        S_CONV = 3'd2,
        S_GAP  = 3'd3,
        S_IDLE = 3'd4
    } seq_state_t;
endpackage

// File: rtl/adc_req_check.sv
// Decodes a requested channel number into a legality flag and a one-hot code.
module adc_req_check #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 2
) (
    input  logic [CH_W-1:0]   code,
    output logic              legal,
    output logic [NUM_CH-1:0] onehot
);
    always_comb legal = (int'(code) < NUM_CH);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign onehot[i] = (code == CH_W'(i));
    end
endmodule

// File: rtl/adc_seq_timer.sv
// Loadable down counter shared by the wake window and the conversion timeout.
module adc_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_capture.sv
// Result holding registers and single-cycle status pulses.
module adc_seq_capture #(
    parameter int DATA_W = 10,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              abort,
    input  logic              bad_req,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CH_W-1:0]   chan_in,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic [CH_W-1:0]   done_chan,
    output logic              tmo,
    output logic              err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            tmo       <= 1'b0;
            err       <= 1'b0;
            done_data <= '0;
            done_chan <= '0;
        end else begin
            done <= hit;
            tmo  <= abort;
            err  <= bad_req;
            if (hit) begin
                done_data <= data_in;
            end
            if (hit || abort) begin
                done_chan <= chan_in;
            end
        end
    end
endmodule

// File: rtl/adc_chsel_seq.sv
module adc_chsel_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int CH_W    = $clog2(NUM_CH) + 1,
    parameter int DATA_W  = 10,
    parameter int WAKE_W  = 4,
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [WAKE_W-1:0] wake_cycles,
    input  logic              keep_pwr,
    output logic              req_ready,
    output logic              req_err,
    output logic              adc_pd,
    output logic [NUM_CH-1:0] adc_sel,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_data,
    output logic              done,
    output logic [CH_W-1:0]   done_chan,
    output logic [DATA_W-1:0] done_data,
    output logic              tmo_abort
);
    localparam int TMO_W = $clog2(TIMEOUT + 1);
    localparam int CNT_W = (WAKE_W > TMO_W) ? WAKE_W : TMO_W;
    localparam logic [CNT_W-1:0] TMO_LOAD = CNT_W'(TIMEOUT - 1);

    seq_state_t        state_q, state_d;
    logic [CH_W-1:0]   ch_q;
    logic [NUM_CH-1:0] oh_q;
    logic              legal;
    logic [NUM_CH-1:0] req_oh;
    logic              ch_load;
    logic              tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              cap_hit, cap_abort, bad_req;

    adc_req_check #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_check (
        .code   (req_chan),
        .legal  (legal),
        .onehot (req_oh)
    );

    adc_seq_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    adc_seq_capture #(.DATA_W(DATA_W), .CH_W(CH_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (cap_hit),
        .abort     (cap_abort),
        .bad_req   (bad_req),
        .data_in   (adc_data),
        .chan_in   (ch_q),
        .done      (done),
        .done_data (done_data),
        .done_chan (done_chan),
        .tmo       (tmo_abort),
        .err       (req_err)
    );

    // State register and latched channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            ch_q    <= '0;
            oh_q    <= '0;
        end else begin
            state_q <= state_d;
            if (ch_load) begin
                ch_q <= req_chan;
                oh_q <= req_oh;
            end
        end
    end

    // Next state and control strobes
    always_comb begin
        state_d   = state_q;
        ch_load   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tmr_dec   = 1'b0;
        cap_hit   = 1'b0;
        cap_abort = 1'b0;
        bad_req   = 1'b0;
        unique case (state_q)
            S_OFF: begin
                if (req_valid) begin
                    if (legal) begin
                        ch_load  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(wake_cycles);
                        state_d  = S_WAKE;
                    end else begin
                        bad_req = 1'b1;
                    end
                end
            end
            S_WAKE: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMO_LOAD;
                    state_d  = S_CONV;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            S_CONV: begin
                if (adc_valid) begin
                    cap_hit = 1'b1;
                    state_d = S_GAP;
                end else if (tmr_zero) begin
                    cap_abort = 1'b1;
                    state_d   = S_GAP;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            S_GAP: begin
                state_d = S_IDLE;
            end
            S_IDLE: begin
                if (req_valid && legal) begin
                    ch_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMO_LOAD;
                    state_d  = S_CONV;
                end else begin
                    bad_req = req_valid;
                    if (!keep_pwr) begin
                        state_d = S_OFF;
                    end
                end
            end
            default: state_d = S_OFF;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        adc_pd    = (state_q == S_OFF);
        req_ready = (state_q == S_OFF) || (state_q == S_IDLE);
        adc_sel   = (state_q == S_CONV) ? oh_q : '0;
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_err,
    input logic              adc_pd,
    input logic [NUM_CH-1:0] adc_sel,
    input logic              adc_valid,
    input logic              done,
    input logic              tmo_abort
);
    // R1
    onehot0_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(adc_sel));

    // R2
    sel_via_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sel != '0 && $past(adc_sel) != '0) |-> adc_sel == $past(adc_sel));

    // R2
    gap_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adc_sel) != '0 && adc_sel == '0) |=> adc_sel == '0);

    // R3
    pd_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_pd |-> adc_sel == '0);

    // R6
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(adc_valid) && $past(adc_sel) != '0 && adc_sel == '0));

    // R7
    done_tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && tmo_abort));

    // R7
    tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_abort |-> ($past(adc_sel) != '0 && adc_sel == '0));

    // R8
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> ($past(req_valid) && $past(req_ready)));
endmodule

bind adc_chsel_seq adc_seq_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_err   (req_err),
    .adc_pd    (adc_pd),
    .adc_sel   (adc_sel),
    .adc_valid (adc_valid),
    .done      (done),
    .tmo_abort (tmo_abort)
);

// File: tb/test_adc_chsel_seq.sv
module test_adc_chsel_seq;
    localparam int NUM_CH = 2;
    localparam int CH_W   = 2;
    localparam int DATA_W = 10;
    localparam int WAKE_W = 3;
    localparam int TMO    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [CH_W-1:0]   req_chan = '0;
    logic [WAKE_W-1:0] wake_cycles = '0;
    logic              keep_pwr = 1'b1;
    logic              req_ready, req_err, adc_pd, done, tmo_abort;
    logic [NUM_CH-1:0] adc_sel;
    logic              adc_valid;
    logic [DATA_W-1:0] adc_data;
    logic [CH_W-1:0]   done_chan;
    logic [DATA_W-1:0] done_data;

    always #10 clk = ~clk;

    adc_chsel_seq #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W),
        .WAKE_W(WAKE_W), .TIMEOUT(TMO)
    ) i_adc_chsel_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .wake_cycles(wake_cycles), .keep_pwr(keep_pwr), .req_ready(req_ready),
        .req_err(req_err), .adc_pd(adc_pd), .adc_sel(adc_sel),
        .adc_valid(adc_valid), .adc_data(adc_data), .done(done),
        .done_chan(done_chan), .done_data(done_data), .tmo_abort(tmo_abort)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] mdata(input int ch, input int idx);
        return DATA_W'((ch * 211 + idx * 37 + 3) % 1024);
    endfunction

    // Converter model: answers model_lat cycles after a zero-to-nonzero select edge
    int model_lat = -1;
    bit stray = 0;
    int conv_idx = 0;
    int proto_bad = 0;
    initial begin
        logic [NUM_CH-1:0] prev_sel;
        bit armed;
        int m_cnt;
        int m_ch;
        prev_sel = '0;
        armed = 0;
        m_cnt = 0;
        m_ch = 0;
        adc_valid = 1'b0;
        adc_data = '0;
        forever begin
            @(negedge clk);
            adc_valid = 1'b0;
            if (stray) begin
                adc_valid = 1'b1;
                adc_data = 10'h155;
                stray = 0;
            end
            if ($countones(adc_sel) > 1) proto_bad++;
            if (prev_sel != '0 && adc_sel != '0 && adc_sel != prev_sel) proto_bad++;
            if (prev_sel == '0 && adc_sel != '0 && model_lat >= 0) begin
                armed = 1;
                m_cnt = model_lat;
                conv_idx++;
                for (int i = 0; i < NUM_CH; i++) if (adc_sel[i]) m_ch = i;
            end
            if (armed) begin
                if (m_cnt == 0) begin
                    adc_valid = 1'b1;
                    adc_data = mdata(m_ch, conv_idx);
                    armed = 0;
                end else begin
                    m_cnt--;
                end
            end
            prev_sel = adc_sel;
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
    endtask

    // One request; checks timing against the cycle counts in the requirements
    task automatic run_conv(input int ch, input int lat, input int wake, input bit keep);
        bit from_off;
        int base, sel_n, done_n, tmo_n, exp_idx;
        wait_ready();
        from_off = adc_pd;
        base = from_off ? wake + 1 : 0;
        model_lat = lat;
        wake_cycles = WAKE_W'(wake);
        keep_pwr = keep;
        req_valid = 1'b1;
        req_chan = CH_W'(ch);
        exp_idx = conv_idx + 1;
        @(negedge clk);
        req_valid = 1'b0;
        if (ch >= NUM_CH) begin
            chk(req_err == 1'b1, "R8 error pulse", int'(req_err), 1);
            chk(adc_sel == '0 && req_ready, "R8 no conversion", int'(adc_sel), 0);
            @(negedge clk);
            chk(req_err == 1'b0, "R8 single pulse", int'(req_err), 0);
            chk(adc_sel == '0, "R8 no select", int'(adc_sel), 0);
            return;
        end
        sel_n = 0;
        done_n = 0;
        tmo_n = 0;
        for (int n = 1; n <= base + TMO + 4; n++) begin
            if (n > 1) @(negedge clk);
            if (n <= base) chk(adc_pd == 1'b0 && adc_sel == '0, "R4 wake window", int'(adc_sel), 0);
            if (adc_sel != '0 && sel_n == 0) begin
                sel_n = n;
                chk(adc_sel == NUM_CH'(1 << ch), "R1 select code", int'(adc_sel), 1 << ch);
            end
            if (done) begin
                chk(done_n == 0, "R6 single done", n, done_n);
                done_n = n;
                chk(done_data == mdata(ch, exp_idx), "R6 result", int'(done_data), int'(mdata(ch, exp_idx)));
                chk(int'(done_chan) == ch, "R6 channel", int'(done_chan), ch);
            end
            if (tmo_abort) begin
                chk(tmo_n == 0, "R7 single abort", n, tmo_n);
                tmo_n = n;
                chk(adc_sel == '0, "R7 select released", int'(adc_sel), 0);
            end
        end
        if (from_off) chk(sel_n == base + 1, "R4 select after wake", sel_n, base + 1);
        else          chk(sel_n == 1, "R5 warm start", sel_n, 1);
        if (lat >= 0 && lat <= TMO - 1) begin
            chk(done_n == base + 2 + lat, "R6 done cycle", done_n, base + 2 + lat);
            chk(tmo_n == 0, "R7 no abort on capture", tmo_n, 0);
        end else begin
            chk(tmo_n == base + TMO + 1, "R7 abort cycle", tmo_n, base + TMO + 1);
            chk(done_n == 0, "R9 late valid ignored", done_n, 0);
        end
        chk(adc_pd == !keep, "R10 power after idle", int'(adc_pd), int'(!keep));
    endtask

    initial begin
        int first_idx;
        int dn;
        bit bad_err;
        repeat (3) @(negedge clk);
        chk(adc_pd == 1'b1 && req_ready == 1'b1, "R11 reset power and ready", int'(adc_pd), 1);
        chk(adc_sel == '0 && !done && !tmo_abort && !req_err, "R11 reset outputs", int'(adc_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_pd == 1'b1 && adc_sel == '0, "R3 off after reset", int'(adc_pd), 1);

        // Sweep: wake length x channel code x converter latency, alternating keep_pwr
        for (int w = 0; w < 4; w++) begin
            for (int c = 0; c < 4; c++) begin
                for (int li = 0; li < 5; li++) begin
                    int lat;
                    lat = (li == 0) ? 0 : (li == 1) ? 2 : (li == 2) ? TMO - 1 : (li == 3) ? TMO : -1;
                    run_conv(c, lat, w, ((w + c + li) % 2) == 1);
                end
            end
        end

        // R9: requests during a conversion are ignored
        run_conv(0, 0, 0, 1'b1);
        wait_ready();
        model_lat = 3;
        first_idx = conv_idx + 1;
        req_valid = 1'b1;
        req_chan = 2'd1;
        @(negedge clk);
        req_chan = 2'd0;
        dn = 0;
        bad_err = 0;
        for (int n = 1; n <= 10; n++) begin
            if (n > 1) @(negedge clk);
            if (n == 2) req_chan = 2'd3;
            if (n == 4) req_valid = 1'b0;
            if (req_err) bad_err = 1;
            if (done) dn = n;
        end
        chk(!bad_err, "R9 no error while busy", int'(bad_err), 0);
        chk(dn == 5, "R9 original conversion completes", dn, 5);
        chk(int'(done_chan) == 1 && done_data == mdata(1, first_idx), "R9 original channel kept", int'(done_chan), 1);
        chk(conv_idx == first_idx, "R9 no extra conversion", conv_idx, first_idx);
        req_valid = 1'b0;

        // R9: stray valid while idle
        wait_ready();
        keep_pwr = 1'b1;
        stray = 1;
        dn = 0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk(dn == 0, "R9 stray valid ignored", dn, 0);

        // R10: legal request and power-off in the same idle cycle
        wait_ready();
        chk(adc_pd == 1'b0, "R10 still powered", int'(adc_pd), 0);
        model_lat = 1;
        keep_pwr = 1'b0;
        req_valid = 1'b1;
        req_chan = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(adc_pd == 1'b0 && adc_sel == 2'b10, "R10 request beats power-off", int'(adc_sel), 2);
        repeat (6) @(negedge clk);
        chk(adc_pd == 1'b1, "R10 off after conversion", int'(adc_pd), 1);

        chk(proto_bad == 0, "R2 select only changes via zero", proto_bad, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule